// File: doc/BRIEF.md
# Receive Character Buffer with Per-Frame Error Status

This block sits between the serial receive shifter of a UART and the host-side register interface. The shifter hands over each completed character along with the value sampled for its first stop bit and a parity-failure indication. The block keeps that character in a holding stage and moves it into a two-entry queue whenever a slot is free. Each queue entry carries the character and its own error status. Because the flags travel with their frame, the host always sees the status of the character at the head of the queue.

The host samples the status outputs first and then pulses the read strobe. The read strobe returns the head character and moves the queue to the next entry. A receive-complete flag shows that unread data is present. A level interrupt request follows that flag while the interrupt enable is set. Data is lost only when the queue is full, a finished character is waiting in the holding stage, and the shifter reports another start bit. In that case the waiting character is given up, and the next character to enter the queue is marked with an overrun flag. Clearing the receiver enable discards everything that is queued or held.

Top module: `rx_char_buffer`

## Requirements
- R1: `rx_ready` is 1 exactly when the queue holds at least one unread character. Out of reset it is 0. A character presented on `frm_valid` reaches the queue two clock edges later when a slot is free, and `rx_ready` rises then.
- R2: While `rx_enable` is 0, the queue and the holding stage are emptied at every clock edge and `frm_valid` is ignored, so `rx_ready` is 0 after the first edge with the enable low.
- R3: `irq` is a level equal to `rx_ready AND irq_enable`. It stays high until reads have emptied the queue or the enable is cleared.
- R4: The queue holds at most two characters. `flag_frame`, `flag_overrun` and `flag_parity` always show the stored status of the head entry, and they are 0 when the queue is empty.
- R5: `rd_data` shows the head character. A `rd_strobe` pulse while the queue is not empty removes the head, so the status of the following entry appears from the next cycle.
- R6: `flag_frame` of an entry is 1 when `frm_stop` (the first stop bit) was 0 for that frame, and 0 when it was 1. No other stop bit enters the block.
- R7: An overrun occurs when, in one cycle, the queue is full, no read is removing an entry, the holding stage is occupied and `start_seen` is 1. The next character to enter the queue then carries `flag_overrun` = 1.
- R8: The overrun indication clears when a character enters the queue. The character after the one that carries the flag enters with `flag_overrun` = 0.
- R9: `flag_parity` of an entry is `frm_par_err AND parity_check` as sampled when the frame was presented, so it is always 0 while parity checking is disabled.
- R10: The error flags have no effect on `irq`: with `irq_enable` = 0, `irq` stays 0 whatever flags the head entry carries.
- R11: While the queue is full, a finished character waits in the holding stage. It enters the queue on the edge of the first read that frees a slot. A newer frame that arrives before that edge replaces the waiting one.
- R12: A read and an entry into the queue in the same cycle leave the count unchanged and advance both ends. A read from an empty queue changes nothing, and `rd_data` then shows the last character that was read (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_enable | input | 1 | Receiver enable; low flushes the queue and the holding stage |
| irq_enable | input | 1 | Receive-complete interrupt enable |
| parity_check | input | 1 | Parity checking enabled |
| frm_valid | input | 1 | One-cycle pulse: a completed frame is presented |
| frm_data | input | DATA_W | Character of the presented frame |
| frm_stop | input | 1 | Sampled value of the first stop bit |
| frm_par_err | input | 1 | Parity mismatch found by the upstream checker |
| start_seen | input | 1 | One-cycle pulse: a new start bit was detected |
| rd_strobe | input | 1 | Host read of the data register |
| rx_ready | output | 1 | Unread data present |
| irq | output | 1 | Level interrupt request |
| flag_frame | output | 1 | Framing error of the head entry |
| flag_overrun | output | 1 | Overrun mark of the head entry |
| flag_parity | output | 1 | Parity error of the head entry |
| rd_data | output | DATA_W | Head character, or the last character read when empty |

## Verification
Single frames with each error combination are presented and read back one by one. This shows that every flag belongs to its own frame and is not shared across entries. A burst of three frames with no reads, followed by a start pulse and a fourth frame, tells a frame that waits in the holding stage apart from one that is overwritten. It also shows which entry the overrun mark lands on and that the mark does not carry over to the next frame. Reads placed in the same cycle as a queue entry, reads from an empty queue, parity checking turned off and the interrupt enable cleared each isolate one corner. A flush with frames queued and held shows that nothing survives when the receiver enable drops.

// File: rtl/rx_char_buffer_pkg.sv
package rx_char_buffer_pkg;

    typedef struct packed {
        logic frame;
        logic overrun;
        logic parity;
    } rxb_flags_t;

    localparam rxb_flags_t RXB_FLAGS_CLEAR = '{frame: 1'b0, overrun: 1'b0, parity: 1'b0};

    function automatic rxb_flags_t rxb_make_flags(input logic stop_bit,
                                                  input logic par_bad,
                                                  input logic par_on);
        rxb_flags_t f;
        f.frame   = ~stop_bit;
        f.overrun = 1'b0;
        f.parity  = par_bad & par_on;
        return f;
    endfunction

endpackage

// File: rtl/rxb_hold_stage.sv
module rxb_hold_stage
    import rx_char_buffer_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              parity_on,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_stop,
    input  logic              in_par_bad,
    input  logic              start_pulse,
    input  logic              q_full,
    input  logic              q_pop,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output rxb_flags_t        push_flags
);

    logic              held_valid;
    logic [DATA_W-1:0] held_data;
    rxb_flags_t        held_flags;
    logic              ovr_pending;
    logic              loss_event;

    assign push       = enable && held_valid && (!q_full || q_pop);
    assign loss_event = enable && held_valid && q_full && !q_pop && start_pulse;

    assign push_data          = held_data;
    assign push_flags.frame   = held_flags.frame;
    assign push_flags.parity  = held_flags.parity;
    assign push_flags.overrun = ovr_pending;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            held_valid  <= 1'b0;
            held_data   <= '0;
            held_flags  <= RXB_FLAGS_CLEAR;
            ovr_pending <= 1'b0;
        end else begin
            if (in_valid) begin
                held_valid <= 1'b1;
                held_data  <= in_data;
                held_flags <= rxb_make_flags(in_stop, in_par_bad, parity_on);
            end else if (push) begin
                held_valid <= 1'b0;
            end
            if (loss_event) begin
                ovr_pending <= 1'b1;
            end else if (push) begin
                ovr_pending <= 1'b0;
            end
        end
    end

    // A waiting frame is kept while no slot opens
    assert_hold_kept_R11: assert property (@(posedge clk) disable iff (rst)
        (enable && held_valid && q_full && !q_pop && !in_valid) |=> held_valid);

    // An overrun always marks the next frame that enters the queue
    assert_overrun_marked_R7: assert property (@(posedge clk) disable iff (rst)
        (loss_event && enable) |=> (ovr_pending || !enable));

endmodule

// File: rtl/rxb_queue.sv
module rxb_queue
    import rx_char_buffer_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  rxb_flags_t        push_flags,
    input  logic              pop_req,
    output logic              pop,
    output logic              full,
    output logic              empty,
    output logic [DATA_W-1:0] head_data,
    output rxb_flags_t        head_flags,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    logic [DATA_W-1:0] data_mem [DEPTH];
    rxb_flags_t        flag_mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic [CW-1:0]     count;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign empty      = (count == '0);
    assign full       = (count == CW'(DEPTH));
    assign pop        = pop_req && !empty;
    assign head_data  = data_mem[rd_ptr];
    assign head_flags = flag_mem[rd_ptr];
    assign level      = count;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= step_ptr(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= step_ptr(rd_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                data_mem[i] <= '0;
                flag_mem[i] <= RXB_FLAGS_CLEAR;
            end else if (push && !flush && wr_ptr == PW'(i)) begin
                data_mem[i] <= push_data;
                flag_mem[i] <= push_flags;
            end
        end
    end

    // Never write into a full queue unless a read frees a slot the same cycle
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (push && full) |-> pop);

    // A read from an empty queue leaves the read side untouched
    assert_empty_read_R12: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty && !flush) |=> $stable(rd_ptr));

endmodule

// File: rtl/rxb_host_view.sv
module rxb_host_view
    import rx_char_buffer_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_empty,
    input  logic              q_pop,
    input  logic [DATA_W-1:0] q_head_data,
    input  rxb_flags_t        q_head_flags,
    input  logic              int_en,
    output logic              ready,
    output logic              int_req,
    output rxb_flags_t        flags,
    output logic [DATA_W-1:0] data
);

    logic [DATA_W-1:0] last_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_read <= '0;
        end else if (q_pop) begin
            last_read <= q_head_data;
        end
    end

    assign ready   = !q_empty;
    assign int_req = ready && int_en;
    assign flags   = q_empty ? RXB_FLAGS_CLEAR : q_head_flags;
    assign data    = q_empty ? last_read : q_head_data;

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
    import rx_char_buffer_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enable,
    input  logic              irq_enable,
    input  logic              parity_check,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_stop,
    input  logic              frm_par_err,
    input  logic              start_seen,
    input  logic              rd_strobe,
    output logic              rx_ready,
    output logic              irq,
    output logic              flag_frame,
    output logic              flag_overrun,
    output logic              flag_parity,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic              q_push;
    logic [DATA_W-1:0] q_push_data;
    rxb_flags_t        q_push_flags;
    logic              q_pop;
    logic              q_full;
    logic              q_empty;
    logic [DATA_W-1:0] q_head_data;
    rxb_flags_t        q_head_flags;
    logic [CW-1:0]     q_level;
    rxb_flags_t        view_flags;

    rxb_hold_stage #(.DATA_W(DATA_W)) i_hold (
        .clk         (clk),
        .rst         (rst),
        .enable      (rx_enable),
        .parity_on   (parity_check),
        .in_valid    (frm_valid),
        .in_data     (frm_data),
        .in_stop     (frm_stop),
        .in_par_bad  (frm_par_err),
        .start_pulse (start_seen),
        .q_full      (q_full),
        .q_pop       (q_pop),
        .push        (q_push),
        .push_data   (q_push_data),
        .push_flags  (q_push_flags)
    );

    rxb_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_queue (
        .clk        (clk),
        .rst        (rst),
        .flush      (!rx_enable),
        .push       (q_push),
        .push_data  (q_push_data),
        .push_flags (q_push_flags),
        .pop_req    (rd_strobe),
        .pop        (q_pop),
        .full       (q_full),
        .empty      (q_empty),
        .head_data  (q_head_data),
        .head_flags (q_head_flags),
        .level      (q_level)
    );

    rxb_host_view #(.DATA_W(DATA_W)) i_view (
        .clk          (clk),
        .rst          (rst),
        .q_empty      (q_empty),
        .q_pop        (q_pop),
        .q_head_data  (q_head_data),
        .q_head_flags (q_head_flags),
        .int_en       (irq_enable),
        .ready        (rx_ready),
        .int_req      (irq),
        .flags        (view_flags),
        .data         (rd_data)
    );

    assign flag_frame   = view_flags.frame;
    assign flag_overrun = view_flags.overrun;
    assign flag_parity  = view_flags.parity;

    // Dropping the enable leaves nothing readable after the next edge
    assert_flush_empty_R2: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !rx_ready);

    // The request is only raised while the queue holds data
    assert_irq_needs_data_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (q_level != '0));

    // Occupancy never exceeds the queue depth
    assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
        q_level <= CW'(DEPTH));

endmodule

// File: tb/test_rx_char_buffer.sv
module test_rx_char_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_enable = 1'b0;
    logic          irq_enable = 1'b0;
    logic          parity_check = 1'b0;
    logic          frm_valid = 1'b0;
    logic [DW-1:0] frm_data = '0;
    logic          frm_stop = 1'b1;
    logic          frm_par_err = 1'b0;
    logic          start_seen = 1'b0;
    logic          rd_strobe = 1'b0;
    logic          rx_ready, irq, flag_frame, flag_overrun, flag_parity;
    logic [DW-1:0] rd_data;

    rx_char_buffer #(.DATA_W(DW), .DEPTH(2)) i_rx_char_buffer (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .irq_enable(irq_enable),
        .parity_check(parity_check), .frm_valid(frm_valid), .frm_data(frm_data),
        .frm_stop(frm_stop), .frm_par_err(frm_par_err), .start_seen(start_seen),
        .rd_strobe(rd_strobe), .rx_ready(rx_ready), .irq(irq),
        .flag_frame(flag_frame), .flag_overrun(flag_overrun),
        .flag_parity(flag_parity), .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    typedef struct {
        logic [DW-1:0] d;
        bit fe;
        bit ov;
        bit pe;
    } ent_t;

    ent_t          q[$];
    bit            m_hold_v = 0;
    ent_t          m_hold;
    bit            m_ovp = 0;
    logic [DW-1:0] m_last = '0;

    always @(posedge clk) begin
        if (rst || !rx_enable) begin
            q.delete();
            m_hold_v = 0;
            m_ovp    = 0;
            if (rst) m_last = '0;
        end else begin
            bit   full_now, pop_now, push_now, loss_now;
            ent_t e;
            full_now = (q.size() == 2);
            pop_now  = rd_strobe && (q.size() > 0);
            loss_now = start_seen && m_hold_v && full_now && !pop_now;
            push_now = m_hold_v && (!full_now || pop_now);
            if (pop_now) begin
                m_last = q[0].d;
                void'(q.pop_front());
            end
            if (push_now) begin
                e    = m_hold;
                e.ov = m_ovp;
                q.push_back(e);
            end
            if (loss_now) m_ovp = 1;
            else if (push_now) m_ovp = 0;
            if (frm_valid) begin
                m_hold_v    = 1;
                m_hold.d    = frm_data;
                m_hold.fe   = !frm_stop;
                m_hold.pe   = frm_par_err && parity_check;
                m_hold.ov   = 0;
            end else if (push_now) begin
                m_hold_v = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit ne;
            ne = (q.size() > 0);
            chk("R1 rx_ready", int'(rx_ready), int'(ne));
            chk("R3 irq", int'(irq), int'(ne && irq_enable));
            chk("R6 R4 flag_frame", int'(flag_frame), ne ? int'(q[0].fe) : 0);
            chk("R7 R4 flag_overrun", int'(flag_overrun), ne ? int'(q[0].ov) : 0);
            chk("R9 R4 flag_parity", int'(flag_parity), ne ? int'(q[0].pe) : 0);
            chk("R5 rd_data", int'(rd_data), ne ? int'(q[0].d) : int'(m_last));
        end
    end

    task automatic cyc(input bit fv, input logic [DW-1:0] d, input bit s1,
                       input bit pb, input bit sd, input bit rp);
        @(posedge clk);
        #1;
        frm_valid   = fv;
        frm_data    = d;
        frm_stop    = s1;
        frm_par_err = pb;
        start_seen  = sd;
        rd_strobe   = rp;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 1, 0, 0, 0);
    endtask

    task automatic look;
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=done");
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset rx_ready", int'(rx_ready), 0);
        chk("R3 reset irq", int'(irq), 0);
        chk("R12 reset rd_data", int'(rd_data), 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        rx_enable = 1'b1;
        irq_enable = 1'b1;
        parity_check = 1'b1;

        // Single frames with distinct error mixes
        cyc(1, 8'hA5, 1, 0, 0, 0);
        idle(2);
        look();
        chk("R1 ready after frame", int'(rx_ready), 1);
        chk("R5 head data", int'(rd_data), 'hA5);
        cyc(0, '0, 1, 0, 0, 1);
        cyc(1, 8'h3C, 0, 0, 0, 0);
        cyc(1, 8'h7E, 1, 1, 0, 0);
        idle(2);
        look();
        chk("R6 frame error on head", int'(flag_frame), 1);
        chk("R4 parity not on head", int'(flag_parity), 0);
        cyc(0, '0, 1, 0, 0, 1);
        idle(1);
        look();
        chk("R5 next head parity", int'(flag_parity), 1);
        chk("R6 next head framing", int'(flag_frame), 0);
        cyc(0, '0, 1, 0, 0, 1);
        idle(2);

        // Fill, wait in hold, overrun, overwrite
        cyc(1, 8'h11, 1, 0, 0, 0);
        cyc(1, 8'h22, 1, 0, 0, 0);
        cyc(1, 8'h33, 1, 0, 0, 0);
        idle(3);
        cyc(0, '0, 1, 0, 1, 0);
        cyc(1, 8'h44, 1, 0, 0, 0);
        idle(2);
        look();
        chk("R11 head still first", int'(rd_data), 'h11);
        cyc(0, '0, 1, 0, 0, 1);
        cyc(0, '0, 1, 0, 0, 1);
        idle(1);
        look();
        chk("R11 overwritten frame", int'(rd_data), 'h44);
        chk("R7 overrun attached", int'(flag_overrun), 1);
        cyc(0, '0, 1, 0, 0, 1);
        cyc(1, 8'h55, 1, 0, 0, 0);
        idle(2);
        look();
        chk("R8 overrun cleared", int'(flag_overrun), 0);
        cyc(0, '0, 1, 0, 0, 1);
        idle(1);

        // Read and entry in the same cycle
        cyc(1, 8'h61, 1, 0, 0, 0);
        cyc(1, 8'h62, 1, 0, 0, 0);
        cyc(1, 8'h63, 1, 0, 0, 0);
        idle(2);
        cyc(0, '0, 1, 0, 0, 1);
        idle(1);
        look();
        chk("R12 still full head", int'(rd_data), 'h62);
        cyc(0, '0, 1, 0, 0, 1);
        cyc(0, '0, 1, 0, 0, 1);
        idle(1);
        look();
        chk("R12 drained", int'(rx_ready), 0);

        // Reads from an empty queue
        cyc(0, '0, 1, 0, 0, 1);
        cyc(0, '0, 1, 0, 0, 1);
        idle(1);
        look();
        chk("R12 empty read keeps last", int'(rd_data), 'h63);

        // Parity checking off
        parity_check = 1'b0;
        cyc(1, 8'h9A, 1, 1, 0, 0);
        idle(2);
        look();
        chk("R9 parity gated", int'(flag_parity), 0);
        cyc(0, '0, 1, 0, 0, 1);
        parity_check = 1'b1;

        // Interrupt disabled, error flags present
        irq_enable = 1'b0;
        cyc(1, 8'hC3, 0, 1, 0, 0);
        idle(2);
        look();
        chk("R10 flags no irq", int'(irq), 0);
        irq_enable = 1'b1;
        idle(1);
        look();
        chk("R3 irq level", int'(irq), 1);

        // Flush with queue full and a frame held
        cyc(1, 8'hD1, 1, 0, 0, 0);
        cyc(1, 8'hD2, 1, 0, 0, 0);
        idle(2);
        @(posedge clk);
        #1;
        rx_enable = 1'b0;
        cyc(1, 8'hEE, 1, 0, 0, 0);
        look();
        chk("R2 flushed", int'(rx_ready), 0);
        chk("R2 irq dropped", int'(irq), 0);
        idle(1);
        @(posedge clk);
        #1;
        rx_enable = 1'b1;
        idle(3);
        look();
        chk("R2 nothing survives", int'(rx_ready), 0);

        idle(2);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule